// File: doc/BRIEF.md
# Keyed Indexed Configuration Port

This block gives a host access to a bank of configuration registers through just two byte-wide I/O locations. The lower location is the index port and the one above it is the data port. After reset the register space is sealed. A host opens it by writing an unlock byte to the index port twice in a row. Once the space is open, each index-port write chooses a register and data-port accesses read or write that register. Writing a lock byte to the index port seals the space again.

The register space has two parts. The global part holds a logical-device selector, read-only identification bytes, and a per-device enable bit. The upper part (indices 0x31 and above) belongs to whichever logical device the selector names. Accesses to it are passed out on a narrow device-side interface: a select value, an index, write data, and one-cycle read and write strobes. The read byte comes back combinationally on `ld_rdata`. The two base addresses are parameters, and the `base_sel` pin chooses between them.

Host reads complete in exactly one cycle and cannot be stalled. The response carries no ready signal, so the host must accept `io_rd_valid` in the cycle it is high. The read data is valid only in that cycle.

Top module: `siocfg_port`

## Requirements
- R1: The index port is at `BASE_A` (0x2E) when `base_sel`=0 and at `BASE_B` (0x4E) when `base_sel`=1, and the data port is one address higher. An access to any other address gives no `io_rd_valid` and no device strobe. If `io_wr` and `io_rd` are both high, the access is treated as a write.
- R2: The space opens only after two consecutive index-port writes of 0x87. After opening, the index is 0x00.
- R3: While the space is sealed, any index-port write other than 0x87 restarts the unlock sequence. This includes such a write that follows a single 0x87.
- R4: While the space is open, an index-port write of 0xAA seals it and clears the index to 0x00. Any other index-port write loads the index.
- R5: While the space is sealed, data-port writes are ignored and reads of either port return 0xFF. No device strobe is raised.
- R6: While the space is open, a read of the index port returns the current index.
- R7: Index 0x07 is an 8-bit read/write logical-device selector. It resets to 0x00 and its value drives `ld_sel`.
- R8: Index 0x20 returns `DEV_ID[15:8]`, index 0x21 returns `DEV_ID[7:0]`, and index 0x22 returns `DEV_REV`. Index 0x23 returns 0x19 and index 0x24 returns 0x34. Writes to any of these indices are ignored.
- R9: Every other index below 0x30 reads 0x00 and ignores writes.
- R10: Index 0x30 holds an enable bit for the selected device. A write stores bit 0 of the data into `ld_enable[ld_sel]`, and a read returns that bit in bit 0 with zeros above it. When `ld_sel` ≥ `NUM_LD`, the read returns 0x00 and the write is ignored. `ld_enable` changes on no other write.
- R11: While the space is open, data-port accesses at indices 0x31–0xFF raise `ld_wr` or `ld_rd` for one cycle, in the same cycle as the host strobe. `ld_idx` carries the index and `ld_wdata` carries the write data. A read returns `ld_rdata`. At most one of the two strobes is high at a time.
- R12: Each accepted read raises `io_rd_valid` in the next cycle, with `io_rdata`, for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 1 | Selects base address A (0) or B (1) |
| io_addr | input | ADDR_W | Host I/O address |
| io_wr | input | 1 | Host write strobe |
| io_rd | input | 1 | Host read strobe |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Read response data |
| io_rd_valid | output | 1 | Read response valid, one cycle |
| ld_sel | output | 8 | Current logical-device selector |
| ld_enable | output | NUM_LD | Per-device enable bits |
| ld_idx | output | 8 | Register index for the device side |
| ld_wdata | output | 8 | Write data for the device side |
| ld_wr | output | 1 | Device register write strobe |
| ld_rd | output | 1 | Device register read strobe |
| ld_rdata | input | 8 | Device register read data |

## Verification
A wrong unlock state becomes visible at the very next read. A space that is open when it should be sealed returns a register value instead of 0xFF, and it raises a device strobe. A space that stays sealed when it should be open returns 0xFF where an identification byte was expected. A corrupted index or selector shows up one cycle after the next read, as the wrong byte or the wrong `ld_sel`/`ld_idx`. A stray enable write is visible on `ld_enable` immediately after the clock edge.

// File: rtl/siocfg_pkg.sv
package siocfg_pkg;
  typedef enum logic [1:0] {ST_LOCKED, ST_KEY1, ST_OPEN} key_state_e;

  localparam logic [7:0] UNLOCK_BYTE  = 8'h87;
  localparam logic [7:0] LOCK_BYTE    = 8'hAA;
  localparam logic [7:0] SEALED_READ  = 8'hFF;

  localparam logic [7:0] IDX_LDSEL    = 8'h07;
  localparam logic [7:0] IDX_DEV_HI   = 8'h20;
  localparam logic [7:0] IDX_DEV_LO   = 8'h21;
  localparam logic [7:0] IDX_REV      = 8'h22;
  localparam logic [7:0] IDX_MAN_HI   = 8'h23;
  localparam logic [7:0] IDX_MAN_LO   = 8'h24;
  localparam logic [7:0] IDX_ENABLE   = 8'h30;
  localparam logic [7:0] IDX_LD_FIRST = 8'h31;

  localparam logic [15:0] MAKER_ID    = 16'h1934;
endpackage

// File: rtl/siocfg_decode.sv
module siocfg_decode #(
  parameter int unsigned       ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_A = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_B = 'h4E
) (
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  output logic              idx_wr,
  output logic              idx_rd,
  output logic              dat_wr,
  output logic              dat_rd
);
  localparam logic [ADDR_W-1:0] STEP = 1;

  logic [ADDR_W-1:0] base;
  logic              hit_idx;
  logic              hit_dat;
  logic              rd_only;

  assign base    = base_sel ? BASE_B : BASE_A;
  assign hit_idx = (io_addr == base);
  assign hit_dat = (io_addr == base + STEP);
  // a write wins when both strobes are raised together
  assign rd_only = io_rd & ~io_wr;

  assign idx_wr = io_wr & hit_idx;
  assign dat_wr = io_wr & hit_dat;
  assign idx_rd = rd_only & hit_idx;
  assign dat_rd = rd_only & hit_dat;
endmodule

// File: rtl/siocfg_keylock.sv
module siocfg_keylock
  import siocfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       idx_wr,
  input  logic [7:0] wdata,
  output logic       cfg_open,
  output logic [7:0] index
);
  key_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_LOCKED;
      index <= 8'h00;
    end else if (idx_wr) begin
      unique case (state)
        ST_LOCKED: state <= (wdata == UNLOCK_BYTE) ? ST_KEY1 : ST_LOCKED;
        ST_KEY1:   state <= (wdata == UNLOCK_BYTE) ? ST_OPEN : ST_LOCKED;
        ST_OPEN: begin
          if (wdata == LOCK_BYTE) begin
            state <= ST_LOCKED;
            index <= 8'h00;
          end else begin
            index <= wdata;
          end
        end
        default: state <= ST_LOCKED;
      endcase
    end
  end

  assign cfg_open = (state == ST_OPEN);

  // R2: opening is always preceded by an unlock byte on the index port
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> ($past(idx_wr) && $past(wdata) == UNLOCK_BYTE));

  // R3: a wrong byte while sealed returns to the start of the sequence
  a_r3_bad_key_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && idx_wr && wdata != UNLOCK_BYTE) |=> (state == ST_LOCKED));

  // R4: lock byte seals the space and clears the index
  a_r4_lock_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && idx_wr && wdata == LOCK_BYTE) |=> (!cfg_open && index == 8'h00));
endmodule

// File: rtl/siocfg_globals.sv
module siocfg_globals
  import siocfg_pkg::*;
#(
  parameter logic [15:0] DEV_ID  = 16'h0A51,
  parameter logic [7:0]  DEV_REV = 8'h13,
  parameter int unsigned NUM_LD  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_open,
  input  logic [7:0]        index,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [7:0]        wdata,
  input  logic [7:0]        ld_rdata,
  output logic [7:0]        ld_sel,
  output logic [NUM_LD-1:0] ld_enable,
  output logic              ld_wr,
  output logic              ld_rd,
  output logic [7:0]        rdata
);
  logic       wr_ok;
  logic       en_wr;
  logic       en_cur;
  logic       dev_space;
  logic [7:0] sel_q;

  assign wr_ok     = cfg_open & dat_wr;
  assign en_wr     = wr_ok & (index == IDX_ENABLE);
  assign dev_space = (index >= IDX_LD_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            sel_q <= 8'h00;
    else if (wr_ok && index == IDX_LDSEL) sel_q <= wdata;
  end

  for (genvar g = 0; g < NUM_LD; g++) begin : g_enable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          ld_enable[g] <= 1'b0;
      else if (en_wr && sel_q == 8'(g))   ld_enable[g] <= wdata[0];
    end
  end

  always_comb begin
    en_cur = 1'b0;
    for (int i = 0; i < NUM_LD; i++)
      if (sel_q == 8'(i)) en_cur = ld_enable[i];
  end

  always_comb begin
    unique case (index)
      IDX_LDSEL:  rdata = sel_q;
      IDX_DEV_HI: rdata = DEV_ID[15:8];
      IDX_DEV_LO: rdata = DEV_ID[7:0];
      IDX_REV:    rdata = DEV_REV;
      IDX_MAN_HI: rdata = MAKER_ID[15:8];
      IDX_MAN_LO: rdata = MAKER_ID[7:0];
      IDX_ENABLE: rdata = {7'b0, en_cur};
      default:    rdata = dev_space ? ld_rdata : 8'h00;
    endcase
  end

  assign ld_sel = sel_q;
  assign ld_wr  = wr_ok & dev_space;
  assign ld_rd  = cfg_open & dat_rd & dev_space;

  // R10: the enable bank moves only on a write to the enable index
  a_r10_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(ld_enable));

  // R7: selector changes only through an open write to its index
  a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ok && index == IDX_LDSEL) |=> $stable(ld_sel));
endmodule

// File: rtl/siocfg_port.sv
module siocfg_port
  import siocfg_pkg::*;
#(
  parameter int unsigned       ADDR_W  = 16,
  parameter logic [ADDR_W-1:0] BASE_A  = 'h2E,
  parameter logic [ADDR_W-1:0] BASE_B  = 'h4E,
  parameter logic [15:0]       DEV_ID  = 16'h0A51,
  parameter logic [7:0]        DEV_REV = 8'h13,
  parameter int unsigned       NUM_LD  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_sel,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              io_rd_valid,
  output logic [7:0]        ld_sel,
  output logic [NUM_LD-1:0] ld_enable,
  output logic [7:0]        ld_idx,
  output logic [7:0]        ld_wdata,
  output logic              ld_wr,
  output logic              ld_rd,
  input  logic [7:0]        ld_rdata
);
  logic       idx_wr, idx_rd, dat_wr, dat_rd;
  logic       cfg_open;
  logic [7:0] index;
  logic [7:0] glob_rdata;

  siocfg_decode #(.ADDR_W(ADDR_W), .BASE_A(BASE_A), .BASE_B(BASE_B)) u_decode (
    .base_sel (base_sel),
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .idx_wr   (idx_wr),
    .idx_rd   (idx_rd),
    .dat_wr   (dat_wr),
    .dat_rd   (dat_rd)
  );

  siocfg_keylock u_keylock (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx_wr   (idx_wr),
    .wdata    (io_wdata),
    .cfg_open (cfg_open),
    .index    (index)
  );

  siocfg_globals #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV), .NUM_LD(NUM_LD)) u_globals (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_open  (cfg_open),
    .index     (index),
    .dat_wr    (dat_wr),
    .dat_rd    (dat_rd),
    .wdata     (io_wdata),
    .ld_rdata  (ld_rdata),
    .ld_sel    (ld_sel),
    .ld_enable (ld_enable),
    .ld_wr     (ld_wr),
    .ld_rd     (ld_rd),
    .rdata     (glob_rdata)
  );

  assign ld_idx   = index;
  assign ld_wdata = io_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rd_valid <= 1'b0;
      io_rdata    <= 8'h00;
    end else begin
      io_rd_valid <= idx_rd | dat_rd;
      if (idx_rd)      io_rdata <= cfg_open ? index      : SEALED_READ;
      else if (dat_rd) io_rdata <= cfg_open ? glob_rdata : SEALED_READ;
    end
  end

  // R12: a response only ever follows a host read strobe
  a_r12_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    io_rd_valid |-> $past(io_rd));

  // R5: no device strobe while sealed
  a_r5_sealed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |-> !(ld_wr || ld_rd));

  // R5: sealed data-port read answers 0xFF
  a_r5_sealed_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && dat_rd) |=> (io_rd_valid && io_rdata == SEALED_READ));

  // R11: device strobes are mutually exclusive
  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld_wr, ld_rd}));
endmodule

// File: tb/sim_siocfg_port.sv
module sim_siocfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        base_sel = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        io_rd_valid;
  logic [7:0]  ld_sel;
  logic [15:0] ld_enable;
  logic [7:0]  ld_idx;
  logic [7:0]  ld_wdata;
  logic        ld_wr;
  logic        ld_rd;
  logic [7:0]  ld_rdata;

  int checks = 0;
  int failures = 0;
  int wr_cnt = 0;
  int rd_cnt = 0;
  logic [7:0] last_sel, last_idx, last_data;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  bit         done = 1'b0;

  always #10 clk = ~clk;

  siocfg_port u0 (
    .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
    .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rd_valid(io_rd_valid), .ld_sel(ld_sel), .ld_enable(ld_enable),
    .ld_idx(ld_idx), .ld_wdata(ld_wdata), .ld_wr(ld_wr), .ld_rd(ld_rd),
    .ld_rdata(ld_rdata)
  );

  // bench-side logical device: data is a fixed function of select and index
  function automatic logic [7:0] dev_val(logic [7:0] sel, logic [7:0] idx);
    return idx ^ {sel[3:0], 4'h5};
  endfunction
  assign ld_rdata = dev_val(ld_sel, ld_idx);

  always @(posedge clk) begin
    if (ld_wr) begin
      wr_cnt++;
      last_sel  <= ld_sel;
      last_idx  <= ld_idx;
      last_data <= ld_wdata;
    end
    if (ld_rd) rd_cnt++;
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard whenever a response appears
  always @(negedge clk) begin
    if (rst_n && io_rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected response", io_rdata, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(io_rdata == e, t, io_rdata, e);
      end
    end
  end

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic io_read(logic [15:0] a, logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
  endtask

  task automatic io_read_none(logic [15:0] a);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    check(io_rd_valid == 1'b0, "R1 foreign address answered", io_rd_valid, 0);
  endtask

  task automatic reg_wr(logic [7:0] idx, logic [7:0] d);
    io_write(16'h2E, idx);
    io_write(16'h2F, d);
  endtask

  task automatic reg_rd(logic [7:0] idx, logic [7:0] e, string t);
    io_write(16'h2E, idx);
    io_read(16'h2F, e, t);
  endtask

  task automatic unlock();
    io_write(16'h2E, 8'h87);
    io_write(16'h2E, 8'h87);
  endtask

  task automatic finish_run();
    check(exp_q.size() == 0, "R12 responses missing", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    check(io_rd_valid == 1'b0 && ld_wr == 1'b0 && ld_rd == 1'b0, "R5 reset outputs quiet",
          {io_rd_valid, ld_wr, ld_rd}, 0);
    check(ld_enable == 16'h0, "R10 reset enables", ld_enable, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: sealed reads and writes
    io_read(16'h2F, 8'hFF, "R5 sealed data read");
    io_read(16'h2E, 8'hFF, "R5 sealed index read");
    w0 = wr_cnt;
    io_write(16'h2F, 8'h5A);
    check(wr_cnt == w0, "R5 sealed write strobed device", wr_cnt, w0);

    // R3: broken sequence, then R2 with the trailing pair
    io_write(16'h2E, 8'h87);
    io_write(16'h2E, 8'h12);
    io_write(16'h2E, 8'h87);
    io_read(16'h2F, 8'hFF, "R3 broken key still sealed");
    io_write(16'h2E, 8'h87);
    io_read(16'h2E, 8'h00, "R2 opened with index 0");

    // R6, R8 identification
    io_write(16'h2E, 8'h22);
    io_read(16'h2E, 8'h22, "R6 index readback");
    io_read(16'h2F, 8'h13, "R8 revision");
    reg_rd(8'h20, 8'h0A, "R8 device id high");
    reg_rd(8'h21, 8'h51, "R8 device id low");
    reg_rd(8'h23, 8'h19, "R8 maker id high");
    reg_rd(8'h24, 8'h34, "R8 maker id low");
    reg_wr(8'h23, 8'h00);
    reg_rd(8'h23, 8'h19, "R8 maker id write ignored");

    // R9 unimplemented globals
    reg_rd(8'h05, 8'h00, "R9 empty index");
    reg_wr(8'h05, 8'h55);
    reg_rd(8'h05, 8'h00, "R9 empty index write ignored");
    reg_rd(8'h2F, 8'h00, "R9 top of global area");

    // R7 selector
    reg_rd(8'h07, 8'h00, "R7 selector reset");
    reg_wr(8'h07, 8'hF5);
    reg_rd(8'h07, 8'hF5, "R7 selector 8 bits");
    check(ld_sel == 8'hF5, "R7 ld_sel port", ld_sel, 8'hF5);

    // R10 enables
    reg_wr(8'h07, 8'h07);
    reg_wr(8'h30, 8'h01);
    check(ld_enable == 16'h0080, "R10 enable device 7", ld_enable, 16'h0080);
    reg_rd(8'h30, 8'h01, "R10 enable readback");
    reg_wr(8'h07, 8'h02);
    reg_rd(8'h30, 8'h00, "R10 other device disabled");
    reg_wr(8'h30, 8'hFF);
    reg_rd(8'h30, 8'h01, "R10 only bit 0 kept");
    check(ld_enable == 16'h0084, "R10 two devices", ld_enable, 16'h0084);
    reg_wr(8'h07, 8'h20);
    reg_wr(8'h30, 8'h01);
    check(ld_enable == 16'h0084, "R10 out-of-range device ignored", ld_enable, 16'h0084);
    reg_rd(8'h30, 8'h00, "R10 out-of-range reads zero");

    // R11 device space
    reg_wr(8'h07, 8'h05);
    w0 = wr_cnt;
    reg_wr(8'h60, 8'h3C);
    check(wr_cnt == w0 + 1, "R11 one device write", wr_cnt, w0 + 1);
    check({last_sel, last_idx, last_data} == {8'h05, 8'h60, 8'h3C}, "R11 device write fields",
          {last_sel, last_idx, last_data}, {8'h05, 8'h60, 8'h3C});
    reg_rd(8'h60, dev_val(8'h05, 8'h60), "R11 device read");
    reg_rd(8'hFF, dev_val(8'h05, 8'hFF), "R11 device read top index");
    reg_rd(8'h31, dev_val(8'h05, 8'h31), "R11 device read first index");
    w0 = rd_cnt;
    reg_rd(8'h30, 8'h00, "R11 enable index stays global");
    check(rd_cnt == w0, "R11 no device strobe at 0x30", rd_cnt, w0);

    // R12 single-cycle response
    io_read(16'h2E, 8'h30, "R12 index read");
    @(negedge clk);
    check(io_rd_valid == 1'b0, "R12 valid lasts one cycle", io_rd_valid, 0);

    // R1 addressing and base select
    io_read_none(16'h0030);
    base_sel = 1'b1;
    io_read_none(16'h002E);
    io_read(16'h4E, 8'h30, "R1 alternate base index read");
    io_write(16'h4E, 8'h22);
    io_read(16'h4F, 8'h13, "R1 alternate base data read");
    base_sel = 1'b0;
    @(negedge clk);
    io_addr = 16'h2E; io_wdata = 8'h21; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    check(io_rd_valid == 1'b0, "R1 write wins over read", io_rd_valid, 0);
    io_read(16'h2E, 8'h21, "R1 simultaneous strobe wrote index");

    // R4 lock, data write ignored while sealed, reopen
    io_write(16'h2E, 8'hAA);
    io_read(16'h2F, 8'hFF, "R4 sealed after lock byte");
    io_read(16'h2E, 8'hFF, "R4 index port sealed");
    io_write(16'h2E, 8'h07);
    io_write(16'h2F, 8'h09);
    unlock();
    io_read(16'h2E, 8'h00, "R4 index cleared by lock");
    reg_rd(8'h07, 8'h05, "R5 sealed write did not reach selector");

    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule